// File: doc/BRIEF.md
# Serial NOR Flash Target Model

This block answers on an SPI link (mode 0, most significant bit first) as a small serial NOR flash. Its storage is an internal byte array that is read and written in one clock cycle. A command starts when chip-select goes low. The first byte is an opcode. Read, program and sector erase then take a three-byte address, sent most significant byte first. The block covers byte reads that continue across addresses, page programming, setting and clearing the write-enable latch, sector and whole-array erase, and a three-byte identification read.

The SPI pins are sampled through two-stage synchronisers in the block's own clock domain. SCLK must therefore stay at most about one quarter of the core clock rate. Erases start after chip-select rises and clear one byte per core clock cycle. The master is expected to wait out that time, because no busy status is provided.

Controller states:
- `S_ERASE` clears the selected range. Reset starts here with the whole array selected.
- `S_OPCODE` waits for the first byte.
- `S_ADDR` collects the three address bytes.
- `S_READ` streams array bytes.
- `S_PROG` writes incoming bytes.
- `S_ID` streams the identification bytes.
- `S_SKIP` discards any further bytes.
- `S_SE_WAIT` and `S_BE_WAIT` hold an accepted erase until deselect.

Transitions:
- Deselect moves the controller from any active state to `S_OPCODE`.
- Deselect moves the controller from either wait state to `S_ERASE`.
- When the last byte of the range has been cleared, `S_ERASE` moves to `S_OPCODE`.
- The opcode byte moves `S_OPCODE` to `S_ADDR`, `S_ID`, `S_BE_WAIT` or `S_SKIP`.
- The third address byte moves `S_ADDR` to `S_READ`, `S_PROG`, `S_SE_WAIT` or `S_SKIP`.

Top module: `spi_nor_responder`

## Requirements
- R1: After reset the whole array reads 0xFF once MEM_BYTES clock cycles have passed. After reset `prog_fault` is 0 and `miso` is 0.
- R2: Bits are taken on rising SCLK and driven on falling SCLK, most significant bit first. The opcode values are: 0x06 latch set, 0x04 latch clear, 0x03 read, 0x02 program, 0x20 sector erase, 0xC7 bulk erase and 0x9F identification. A 24-bit address follows 0x03, 0x02 and 0x20, high byte first.
- R3: Opcode 0x9F returns DEVICE_ID (default 0x5A3C17) as three bytes, high byte first. Any further bytes read as 0x00.
- R4: A read returns the byte at the address and then moves to the next address. The address wraps from MEM_BYTES-1 to 0. Address bits at and above log2(MEM_BYTES) are ignored.
- R5: A program stores the incoming byte ANDed with the old contents, unless ALLOW_SET_BITS=1. The address advances by one per byte.
- R6: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Deselect after a program clears the latch, and so does the start of an erase.
- R7: A program or sector erase issued while the latch is clear leaves the array unchanged. It sets `prog_fault`, which then stays 1 until reset.
- R8: A sector erase sets to 0xFF every byte of the SECTOR_BYTES-aligned sector that holds the address, and no other byte. It runs after deselect.
- R9: A bulk erase sets the whole array to 0xFF. With the latch clear it is ignored and does not set `prog_fault`.
- R10: An unknown opcode, and opcode 0x00, change nothing. All bytes that follow one of them in the same selection are ignored.
- R11: `miso` is 0 while deselected and during opcode, address and ignored bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | SPI chip-select, active low |
| mosi | input | 1 | Serial data into the target |
| miso | output | 1 | Serial data out of the target |
| prog_fault | output | 1 | Sticky flag: program or sector erase rejected |

## Verification
The hardest situation to reach from the pins is an erase that has run while other array locations hold known, non-0xFF data. Only then can a check show that the erase touched the right bytes and no others. The stimulus first programs bytes inside and outside the target sector, including the last array byte. It then issues the erase and waits out the cycles it takes. Finally it reads bytes on both sides of the sector boundary. It also shows that the latch was dropped, by making a program without a fresh latch-set have no effect.

// File: rtl/flash_pkg.sv
package flash_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_SECT  = 8'h20;
    localparam logic [7:0] OP_BULK  = 8'hC7;
    localparam logic [7:0] OP_IDENT = 8'h9F;

    typedef enum logic [3:0] {
        S_OPCODE,
        S_ADDR,
        S_READ,
        S_PROG,
        S_ID,
        S_SKIP,
        S_SE_WAIT,
        S_BE_WAIT,
        S_ERASE
    } fl_state_t;

    typedef enum logic [1:0] {
        K_READ,
        K_PROG,
        K_SECT
    } fl_kind_t;

endpackage

// File: rtl/flash_spi_port.sv
module flash_spi_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic       desel,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       miso
);

    logic [2:0] sclk_p;
    logic [1:0] cs_p;
    logic [1:0] mosi_p;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic       rise;
    logic       fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p <= '0;
            cs_p   <= 2'b11;
            mosi_p <= '0;
        end else begin
            sclk_p <= {sclk_p[1:0], sclk};
            cs_p   <= {cs_p[0], cs_n};
            mosi_p <= {mosi_p[0], mosi};
        end
    end

    assign rise  = sclk_p[1] & ~sclk_p[2];
    assign fall  = ~sclk_p[1] & sclk_p[2];
    assign desel = cs_p[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            byte_done <= 1'b0;
        end else if (desel) begin
            bit_cnt   <= '0;
            tx_sh     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                rx_sh   <= {rx_sh[6:0], mosi_p[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_done <= 1'b1;
                end
            end
            if (tx_load) begin
                tx_sh <= tx_byte;
            end else if (fall && bit_cnt != 3'd0) begin
                tx_sh <= {tx_sh[6:0], 1'b0};
            end
        end
    end

    assign rx_byte = rx_sh;
    assign miso    = tx_sh[7];

endmodule

// File: rtl/flash_storage.sv
module flash_storage #(
    parameter int MEM_BYTES = 1024,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] cells [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
    import flash_pkg::*;
#(
    parameter int          MEM_BYTES      = 1024,
    parameter int          SECTOR_BYTES   = 256,
    parameter logic [23:0] DEVICE_ID      = 24'h5A3C17,
    parameter bit          ALLOW_SET_BITS = 1'b0,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int SW = $clog2(SECTOR_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          desel,
    input  logic          byte_done,
    input  logic [7:0]    rx_byte,
    input  logic [7:0]    rd_data,
    output logic          tx_load,
    output logic [7:0]    tx_byte,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          wel,
    output logic          fault,
    output fl_state_t     state
);

    fl_kind_t      kind;
    logic [AW-1:0] addr;
    logic [1:0]    idx;
    logic [1:0]    id_idx;
    logic          load_pend;
    logic [AW-1:0] er_addr;
    logic [AW-1:0] er_last;

    // State register and all sequential bookkeeping of the controller
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_ERASE;
            kind      <= K_READ;
            addr      <= '0;
            idx       <= '0;
            id_idx    <= '0;
            load_pend <= 1'b0;
            wel       <= 1'b0;
            fault     <= 1'b0;
            er_addr   <= '0;
            er_last   <= AW'(MEM_BYTES - 1);
        end else begin
            load_pend <= byte_done && !desel && state != S_ERASE;
            if (state == S_ERASE) begin
                if (er_addr == er_last) begin
                    state <= S_OPCODE;
                end else begin
                    er_addr <= er_addr + 1'b1;
                end
            end else if (desel) begin
                idx <= '0;
                unique case (state)
                    S_SE_WAIT: begin
                        state   <= S_ERASE;
                        wel     <= 1'b0;
                        er_addr <= {addr[AW-1:SW], {SW{1'b0}}};
                        er_last <= {addr[AW-1:SW], {SW{1'b1}}};
                    end
                    S_BE_WAIT: begin
                        state   <= S_ERASE;
                        wel     <= 1'b0;
                        er_addr <= '0;
                        er_last <= AW'(MEM_BYTES - 1);
                    end
                    S_PROG: begin
                        state <= S_OPCODE;
                        wel   <= 1'b0;
                    end
                    default: state <= S_OPCODE;
                endcase
            end else begin
                if (load_pend) begin
                    if (state == S_READ) begin
                        addr <= addr + 1'b1;
                    end
                    if (state == S_ID && id_idx != 2'd3) begin
                        id_idx <= id_idx + 2'd1;
                    end
                end
                if (byte_done) begin
                    unique case (state)
                        S_OPCODE: begin
                            unique case (rx_byte)
                                OP_WREN: begin
                                    wel   <= 1'b1;
                                    state <= S_SKIP;
                                end
                                OP_WRDI: begin
                                    wel   <= 1'b0;
                                    state <= S_SKIP;
                                end
                                OP_READ: begin
                                    kind  <= K_READ;
                                    idx   <= '0;
                                    state <= S_ADDR;
                                end
                                OP_PROG: begin
                                    kind  <= K_PROG;
                                    idx   <= '0;
                                    state <= S_ADDR;
                                end
                                OP_SECT: begin
                                    kind  <= K_SECT;
                                    idx   <= '0;
                                    state <= S_ADDR;
                                end
                                OP_BULK: state <= wel ? S_BE_WAIT : S_SKIP;
                                OP_IDENT: begin
                                    id_idx <= '0;
                                    state  <= S_ID;
                                end
                                default: state <= S_SKIP;
                            endcase
                        end
                        S_ADDR: begin
                            addr <= {addr[AW-9:0], rx_byte};
                            idx  <= idx + 2'd1;
                            if (idx == 2'd2) begin
                                unique case (kind)
                                    K_READ: state <= S_READ;
                                    K_PROG: begin
                                        if (wel) begin
                                            state <= S_PROG;
                                        end else begin
                                            fault <= 1'b1;
                                            state <= S_SKIP;
                                        end
                                    end
                                    default: begin
                                        if (wel) begin
                                            state <= S_SE_WAIT;
                                        end else begin
                                            fault <= 1'b1;
                                            state <= S_SKIP;
                                        end
                                    end
                                endcase
                            end
                        end
                        S_PROG: addr <= addr + 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

    // Output decode: serial return byte and array write port
    always_comb begin
        tx_load   = load_pend;
        tx_byte   = 8'h00;
        mem_we    = 1'b0;
        mem_addr  = addr;
        mem_wdata = 8'hFF;
        unique case (state)
            S_READ: tx_byte = rd_data;
            S_ID: begin
                unique case (id_idx)
                    2'd0: tx_byte = DEVICE_ID[23:16];
                    2'd1: tx_byte = DEVICE_ID[15:8];
                    2'd2: tx_byte = DEVICE_ID[7:0];
                    default: tx_byte = 8'h00;
                endcase
            end
            S_PROG: begin
                mem_we    = byte_done && !desel;
                mem_wdata = ALLOW_SET_BITS ? rx_byte : (rd_data & rx_byte);
            end
            S_ERASE: begin
                mem_we   = 1'b1;
                mem_addr = er_addr;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spi_nor_responder.sv
module spi_nor_responder
    import flash_pkg::*;
#(
    parameter int          MEM_BYTES      = 1024,
    parameter int          SECTOR_BYTES   = 256,
    parameter logic [23:0] DEVICE_ID      = 24'h5A3C17,
    parameter bit          ALLOW_SET_BITS = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic miso,
    output logic prog_fault
);

    localparam int AW = $clog2(MEM_BYTES);

    logic          desel;
    logic          byte_done;
    logic [7:0]    rx_byte;
    logic          tx_load;
    logic [7:0]    tx_byte;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic          wel;
    fl_state_t     state;

    flash_spi_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .tx_load   (tx_load),
        .tx_byte   (tx_byte),
        .desel     (desel),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (miso)
    );

    flash_ctrl #(
        .MEM_BYTES      (MEM_BYTES),
        .SECTOR_BYTES   (SECTOR_BYTES),
        .DEVICE_ID      (DEVICE_ID),
        .ALLOW_SET_BITS (ALLOW_SET_BITS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .desel     (desel),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .rd_data   (mem_rdata),
        .tx_load   (tx_load),
        .tx_byte   (tx_byte),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .wel       (wel),
        .fault     (prog_fault),
        .state     (state)
    );

    flash_storage #(
        .MEM_BYTES (MEM_BYTES)
    ) u_store (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/spi_nor_checker.sv
module spi_nor_checker
    import flash_pkg::*;
#(
    parameter bit ALLOW_SET_BITS = 1'b0
) (
    input logic      clk,
    input logic      rst_n,
    input logic      desel,
    input logic      miso,
    input logic      prog_fault,
    input logic      wel,
    input logic      mem_we,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input fl_state_t state
);

    p_miso_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> !miso);

    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_fault |=> prog_fault);

    p_prog_needs_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && state == S_PROG) |-> wel);

    p_no_set_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && state == S_PROG && !ALLOW_SET_BITS) |-> ((wdata & ~rdata) == 8'h00));

    p_erase_drops_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ERASE) |-> !wel);

    p_prog_end_drops_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (desel && state == S_PROG) |=> !wel);

    p_deselect_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (desel && (state == S_SKIP || state == S_READ || state == S_ID || state == S_ADDR))
        |=> state == S_OPCODE);

endmodule

bind spi_nor_responder spi_nor_checker #(
    .ALLOW_SET_BITS (ALLOW_SET_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .desel      (desel),
    .miso       (miso),
    .prog_fault (prog_fault),
    .wel        (wel),
    .mem_we     (mem_we),
    .wdata      (mem_wdata),
    .rdata      (mem_rdata),
    .state      (state)
);

// File: tb/test_spi_nor_responder.sv
module test_spi_nor_responder;

    localparam int MEM  = 1024;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    logic prog_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_nor_responder i_spi_nor_responder (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .mosi       (mosi),
        .miso       (miso),
        .prog_fault (prog_fault)
    );

    // op 1 = latch-set then program one byte, op 2 = read one byte and compare
    localparam logic [35:0] VEC [8] = '{
        {4'h1, 24'h000010, 8'hA5}, {4'h2, 24'h000010, 8'hA5},
        {4'h1, 24'h000010, 8'h0F}, {4'h2, 24'h000010, 8'h05},
        {4'h1, 24'h0003FF, 8'h3C}, {4'h2, 24'h0007FF, 8'h3C},
        {4'h1, 24'h000100, 8'h81}, {4'h2, 24'h000011, 8'hFF}
    };

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic unsel();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF + 4) @(negedge clk);
    endtask

    task automatic one_byte_cmd(input logic [7:0] op);
        logic [7:0] d;
        sel();
        xfer(op, d);
        unsel();
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] d;
        xfer(a[23:16], d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
    endtask

    task automatic prog_raw(input logic [23:0] a, input logic [7:0] v);
        logic [7:0] d;
        sel();
        xfer(8'h02, d);
        send_addr(a);
        xfer(v, d);
        unsel();
    endtask

    task automatic prog_we(input logic [23:0] a, input logic [7:0] v);
        one_byte_cmd(8'h06);
        prog_raw(a, v);
    endtask

    task automatic read1(input logic [23:0] a, output logic [7:0] v);
        logic [7:0] d;
        sel();
        xfer(8'h03, d);
        send_addr(a);
        xfer(8'h00, v);
        unsel();
    endtask

    task automatic wait_erase();
        repeat (MEM + 20) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, r1, r2, r3;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wait_erase();

        // R1: reset state
        chk("R1 fault after reset", 24'(prog_fault), 24'h0);
        chk("R1 miso after reset", 24'(miso), 24'h0);
        read1(24'h000000, r);
        chk("R1 cleared byte 0", 24'(r), 24'hFF);
        read1(24'h0003FF, r);
        chk("R1 cleared last byte", 24'(r), 24'hFF);

        // vector table walk (R5 program, R4 read)
        for (int k = 0; k < 8; k++) begin
            if (VEC[k][35:32] == 4'h1) begin
                prog_we(VEC[k][31:8], VEC[k][7:0]);
            end else begin
                read1(VEC[k][31:8], r);
                chk("R4/R5 vector read", 24'(r), 24'(VEC[k][7:0]));
            end
        end
        chk("R7 no fault yet", 24'(prog_fault), 24'h0);

        // R3 / R2 identification
        sel();
        xfer(8'h9F, r);
        chk("R11 miso low on opcode", 24'(r), 24'h0);
        xfer(8'h00, r1); xfer(8'h00, r2); xfer(8'h00, r3); xfer(8'h00, r);
        unsel();
        chk("R3 R2 id bytes", {r1, r2, r3}, 24'h5A3C17);
        chk("R3 id trailing byte", 24'(r), 24'h0);

        // R4 multi-byte read wrapping to address 0
        prog_we(24'h0003FE, 8'h11);
        sel();
        xfer(8'h03, r);
        send_addr(24'h0003FE);
        xfer(8'h00, r1); xfer(8'h00, r2); xfer(8'h00, r3);
        unsel();
        chk("R4 wrap read", {r1, r2, r3}, 24'h113CFF);

        // R5 multi-byte program, address advances
        one_byte_cmd(8'h06);
        sel();
        xfer(8'h02, r);
        send_addr(24'h000020);
        xfer(8'h12, r); xfer(8'h34, r); xfer(8'h56, r);
        unsel();
        sel();
        xfer(8'h03, r);
        send_addr(24'h000020);
        xfer(8'h00, r1); xfer(8'h00, r2); xfer(8'h00, r3);
        unsel();
        chk("R5 burst program", {r1, r2, r3}, 24'h123456);

        // R7 program without latch
        prog_raw(24'h000030, 8'h00);
        read1(24'h000030, r);
        chk("R7 rejected program", 24'(r), 24'hFF);
        chk("R7 fault set", 24'(prog_fault), 24'h1);

        // R6 latch clear opcode
        one_byte_cmd(8'h06);
        one_byte_cmd(8'h04);
        prog_raw(24'h000031, 8'h00);
        read1(24'h000031, r);
        chk("R6 latch cleared by 0x04", 24'(r), 24'hFF);

        // R6 deselect after program drops latch
        prog_we(24'h000032, 8'h00);
        prog_raw(24'h000033, 8'h00);
        read1(24'h000032, r);
        chk("R6 first program ok", 24'(r), 24'h00);
        read1(24'h000033, r);
        chk("R6 latch dropped after program", 24'(r), 24'hFF);

        // R7 sector erase without latch
        sel();
        xfer(8'h20, r);
        send_addr(24'h000010);
        unsel();
        wait_erase();
        read1(24'h000010, r);
        chk("R7 rejected sector erase", 24'(r), 24'h05);

        // R8 sector erase
        read1(24'h000100, r);
        chk("R8 sector preload", 24'(r), 24'h81);
        one_byte_cmd(8'h06);
        sel();
        xfer(8'h20, r);
        send_addr(24'h000105);
        unsel();
        wait_erase();
        read1(24'h000100, r);
        chk("R8 sector start cleared", 24'(r), 24'hFF);
        read1(24'h000010, r);
        chk("R8 lower sector kept", 24'(r), 24'h05);
        read1(24'h0003FF, r);
        chk("R8 upper sector kept", 24'(r), 24'h3C);
        prog_raw(24'h000012, 8'h00);
        read1(24'h000012, r);
        chk("R6 latch dropped by erase", 24'(r), 24'hFF);

        // R9 bulk erase without latch
        one_byte_cmd(8'hC7);
        wait_erase();
        read1(24'h000010, r);
        chk("R9 bulk ignored", 24'(r), 24'h05);

        // R10 unknown opcode and NOP, following bytes ignored
        sel();
        xfer(8'h5B, r);
        xfer(8'h06, r1);
        xfer(8'hB2, r2);
        unsel();
        chk("R11 miso low on ignored bytes", {8'h00, r1, r2}, 24'h0);
        one_byte_cmd(8'h00);
        prog_raw(24'h000014, 8'h00);
        read1(24'h000014, r);
        chk("R10 bytes after unknown opcode ignored", 24'(r), 24'hFF);
        read1(24'h000010, r);
        chk("R10 array unchanged", 24'(r), 24'h05);

        // R11 deselected output
        chk("R11 miso while deselected", 24'(miso), 24'h0);

        // R9 bulk erase with latch
        one_byte_cmd(8'h06);
        one_byte_cmd(8'hC7);
        wait_erase();
        read1(24'h000010, r);
        chk("R9 bulk cleared low", 24'(r), 24'hFF);
        read1(24'h0003FF, r);
        chk("R9 bulk cleared high", 24'(r), 24'hFF);
        read1(24'h000021, r);
        chk("R9 bulk cleared mid", 24'(r), 24'hFF);
        chk("R7 fault still set", 24'(prog_fault), 24'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule